// File: doc/BRIEF.md
# Dual Latch Countdown Timer

This block provides the two 16-bit down-counters of a peripheral adapter. Both count on a prescaled tick-enable pulse rather than on every clock. The first counter has a full 16-bit reload latch. It runs periodically: after it passes zero it shows all ones for one tick and then reloads from the latch, so one period is the latch value plus two ticks. The second counter is a one-shot. It is loaded from an 8-bit low-byte latch together with a high byte written at load time.

Software reaches the block through byte accesses at offsets 4 to 9. The block decodes those offsets into latch writes, counter loads and flag clears, and returns counter and latch bytes on reads. It does not hold the interrupt flags itself. Instead it sends set and clear pulses for the timer-1 and timer-2 flags to a flag register elsewhere. A timer-1 set pulse is sent only when bits 7:6 of the auxiliary control value select the continuous mode.

Top module: `dual_countdown_timer`

## Requirements
- R1: After reset, the timer-1 latch and counter read 0xFFFF, the timer-2 counter reads 0xFFFF and its low latch is 0. No flag pulse is active.
- R2: A counter changes only on a cycle with `tickEn` high or a load, and it moves down by one per tick.
- R3: Timer 1 goes from 0 to 0xFFFF on the next tick, and on the tick after that it reloads from its latch. The period is therefore latch+2 ticks.
- R4: `t1FlagSet` pulses for one cycle, in the same cycle the counter first reads 0, when a tick takes timer 1 to 0 while `auxCtrl[7:6]` = 2'b01. With any other mode value it never pulses.
- R5: A write to offset 4 or offset 6 changes only the low byte of the timer-1 latch. The counter is not affected.
- R6: A write to offset 5 sets the high latch byte and loads the counter from the whole new latch. It also pulses `t1FlagClr` in the next cycle.
- R7: A write to offset 7 sets the high latch byte and pulses `t1FlagClr` in the next cycle. The counter is not loaded.
- R8: Reads return these bytes: offset 4 the low counter byte, offset 5 the high counter byte, offset 6 the low latch byte, offset 7 the high latch byte. A read of offset 4 pulses `t1FlagClr` in the next cycle.
- R9: A write to offset 8 stores the timer-2 low latch and leaves the counter alone. A write to offset 9 loads timer 2 with {written byte, low latch}.
- R10: A read of offset 8 returns the timer-2 low byte and pulses `t2FlagClr` in the next cycle. A read of offset 9 returns the high byte and produces no clear pulse.
- R11: Timer 2 wraps freely from 0 to 0xFFFF. `t2FlagSet` pulses once, when a tick first takes it to 0 after a load, and not again until the next load.
- R12: A load by write to offset 5 or offset 9 takes precedence over a tick in the same cycle.
- R13: Offsets outside 4 to 9 read as 0, and writes to them change no timer state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | Prescaled count enable |
| auxCtrl | input | 8 | Auxiliary control value; bits 7:6 select the timer-1 mode |
| regSel | input | 4 | Byte register offset |
| wrEn | input | 1 | Write strobe |
| wrData | input | 8 | Write byte |
| rdEn | input | 1 | Read strobe; read side effects happen on this cycle |
| rdData | output | 8 | Read byte, combinational from `regSel` |
| t1FlagSet | output | 1 | Timer-1 flag set pulse |
| t1FlagClr | output | 1 | Timer-1 flag clear pulse |
| t2FlagSet | output | 1 | Timer-2 flag set pulse |
| t2FlagClr | output | 1 | Timer-2 flag clear pulse |

## Verification
The assertions check the following on every cycle:
- timer 1 steps from zero to all ones, and from the wrap state to the latch;
- a counter holds still without a tick or a load;
- a load wins over a tick;
- each timer-1 set pulse coincides with a zero count in continuous mode;
- the timer-2 set pulse never repeats back to back.

Only the bench scenarios can show the following:
- the whole latch+2 period;
- the one-shot disarming across a full wrap of timer 2;
- the byte placement of each read and latch write;
- that writes to other offsets or in other modes leave the state untouched.

// File: rtl/dual_timer_pkg.sv
package dual_timer_pkg;
  localparam int unsigned SEL_W = 4;

  localparam logic [SEL_W-1:0] OFS_T1_CNT_LO   = 4'd4;
  localparam logic [SEL_W-1:0] OFS_T1_CNT_HI   = 4'd5;
  localparam logic [SEL_W-1:0] OFS_T1_LATCH_LO = 4'd6;
  localparam logic [SEL_W-1:0] OFS_T1_LATCH_HI = 4'd7;
  localparam logic [SEL_W-1:0] OFS_T2_LO       = 4'd8;
  localparam logic [SEL_W-1:0] OFS_T2_HI       = 4'd9;

  localparam logic [1:0] MODE_CONTINUOUS = 2'b01;

  typedef struct packed {
    logic t1LatchLoWr;
    logic t1LatchHiWr;
    logic t1Load;
    logic t2LatchWr;
    logic t2Load;
  } timer_strobe_t;
endpackage

// File: rtl/dual_timer_ctrl.sv
module dual_timer_ctrl
  import dual_timer_pkg::*;
#(
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned CNT_W = 2 * BYTE_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [7:0]          auxCtrl,
  input  logic [SEL_W-1:0]    regSel,
  input  logic                wrEn,
  input  logic                rdEn,
  input  logic [CNT_W-1:0]    t1Count,
  input  logic [CNT_W-1:0]    t1Latch,
  input  logic [CNT_W-1:0]    t2Count,
  output timer_strobe_t       strobe,
  output logic                contMode,
  output logic [BYTE_W-1:0]   rdData,
  output logic                t1ClrPulse,
  output logic                t2ClrPulse
);
  logic t1ClrReq;
  logic t2ClrReq;

  always_comb begin
    strobe             = '0;
    strobe.t1LatchLoWr = wrEn && (regSel == OFS_T1_CNT_LO || regSel == OFS_T1_LATCH_LO);
    strobe.t1LatchHiWr = wrEn && (regSel == OFS_T1_CNT_HI || regSel == OFS_T1_LATCH_HI);
    strobe.t1Load      = wrEn && (regSel == OFS_T1_CNT_HI);
    strobe.t2LatchWr   = wrEn && (regSel == OFS_T2_LO);
    strobe.t2Load      = wrEn && (regSel == OFS_T2_HI);
  end

  assign contMode = (auxCtrl[7:6] == MODE_CONTINUOUS);

  assign t1ClrReq = (wrEn && (regSel == OFS_T1_CNT_HI || regSel == OFS_T1_LATCH_HI))
                 || (rdEn && regSel == OFS_T1_CNT_LO);
  assign t2ClrReq = rdEn && (regSel == OFS_T2_LO);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      t1ClrPulse <= 1'b0;
      t2ClrPulse <= 1'b0;
    end else begin
      t1ClrPulse <= t1ClrReq;
      t2ClrPulse <= t2ClrReq;
    end
  end

  always_comb begin
    case (regSel)
      OFS_T1_CNT_LO:   rdData = t1Count[BYTE_W-1:0];
      OFS_T1_CNT_HI:   rdData = t1Count[CNT_W-1:BYTE_W];
      OFS_T1_LATCH_LO: rdData = t1Latch[BYTE_W-1:0];
      OFS_T1_LATCH_HI: rdData = t1Latch[CNT_W-1:BYTE_W];
      OFS_T2_LO:       rdData = t2Count[BYTE_W-1:0];
      OFS_T2_HI:       rdData = t2Count[CNT_W-1:BYTE_W];
      default:         rdData = '0;
    endcase
  end

  // R7: high latch write always produces a clear pulse next cycle
  assert_clear_on_latch_hi_R7: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && regSel == OFS_T1_LATCH_HI) |=> t1ClrPulse);

  // R13: one decoded write action at most per cycle among loads and low-latch writes
  assert_single_write_R13: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.t1LatchLoWr, strobe.t1Load, strobe.t2LatchWr, strobe.t2Load}));

  // R10: timer-2 clear pulse only follows a low-byte read
  assert_t2_clear_cause_R10: assert property (@(posedge clk) disable iff (!rstN)
    t2ClrPulse |-> $past(rdEn && regSel == OFS_T2_LO));
endmodule

// File: rtl/dual_timer_datapath.sv
module dual_timer_datapath
  import dual_timer_pkg::*;
#(
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned CNT_W = 2 * BYTE_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                tickEn,
  input  logic                contMode,
  input  timer_strobe_t       strobe,
  input  logic [BYTE_W-1:0]   wrByte,
  output logic [CNT_W-1:0]    t1Count,
  output logic [CNT_W-1:0]    t1Latch,
  output logic [CNT_W-1:0]    t2Count,
  output logic                t1Event,
  output logic                t2Event
);
  localparam logic [CNT_W-1:0] ALL_ONES = '1;
  localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);

  logic              t1Wrap;
  logic [CNT_W-1:0]  t1Next;
  logic [CNT_W-1:0]  t1LoadVal;
  logic [BYTE_W-1:0] t2LatchLo;
  logic              t2Armed;

  // timer 1 latch, byte-wise
  always_ff @(posedge clk) begin
    if (!rstN) begin
      t1Latch <= ALL_ONES;
    end else begin
      if (strobe.t1LatchLoWr) t1Latch[BYTE_W-1:0]     <= wrByte;
      if (strobe.t1LatchHiWr) t1Latch[CNT_W-1:BYTE_W] <= wrByte;
    end
  end

  assign t1LoadVal = {wrByte, t1Latch[BYTE_W-1:0]};

  always_comb begin
    if (t1Wrap)               t1Next = t1Latch;
    else if (t1Count == '0)   t1Next = ALL_ONES;
    else                      t1Next = t1Count - ONE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      t1Count <= ALL_ONES;
      t1Wrap  <= 1'b0;
      t1Event <= 1'b0;
    end else begin
      t1Event <= 1'b0;
      if (strobe.t1Load) begin
        t1Count <= t1LoadVal;
        t1Wrap  <= 1'b0;
      end else if (tickEn) begin
        t1Count <= t1Next;
        t1Wrap  <= !t1Wrap && (t1Count == '0);
        t1Event <= contMode && (t1Next == '0);
      end
    end
  end

  // timer 2: one-shot with low-byte latch
  always_ff @(posedge clk) begin
    if (!rstN) begin
      t2LatchLo <= '0;
    end else if (strobe.t2LatchWr) begin
      t2LatchLo <= wrByte;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      t2Count <= ALL_ONES;
      t2Armed <= 1'b0;
      t2Event <= 1'b0;
    end else begin
      t2Event <= 1'b0;
      if (strobe.t2Load) begin
        t2Count <= {wrByte, t2LatchLo};
        t2Armed <= 1'b1;
      end else if (tickEn) begin
        t2Count <= t2Count - ONE;
        if (t2Armed && t2Count == ONE) begin
          t2Event <= 1'b1;
          t2Armed <= 1'b0;
        end
      end
    end
  end

  // R3: zero steps to all ones
  assert_zero_to_ones_R3: assert property (@(posedge clk) disable iff (!rstN)
    (tickEn && !strobe.t1Load && !t1Wrap && t1Count == '0) |=> (t1Count == ALL_ONES));

  // R3: wrap state reloads from latch
  assert_wrap_reload_R3: assert property (@(posedge clk) disable iff (!rstN)
    (tickEn && !strobe.t1Load && t1Wrap) |=> (t1Count == $past(t1Latch)));

  // R2: no tick and no load keeps both counters
  assert_hold_t1_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!tickEn && !strobe.t1Load) |=> $stable(t1Count));
  assert_hold_t2_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!tickEn && !strobe.t2Load) |=> $stable(t2Count));

  // R4: event coincides with zero count in continuous mode
  assert_event_mode_R4: assert property (@(posedge clk) disable iff (!rstN)
    t1Event |-> (t1Count == '0 && $past(contMode) && $past(tickEn)));

  // R12: load wins over a tick
  assert_load_wins_R12: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.t1Load && tickEn) |=> (t1Count == {$past(wrByte), $past(t1Latch[BYTE_W-1:0])}));

  // R11: one-shot event never repeats on the next cycle
  assert_t2_oneshot_R11: assert property (@(posedge clk) disable iff (!rstN)
    t2Event |=> !t2Event);
endmodule

// File: rtl/dual_countdown_timer.sv
module dual_countdown_timer
  import dual_timer_pkg::*;
#(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic [7:0]        auxCtrl,
  input  logic [3:0]        regSel,
  input  logic              wrEn,
  input  logic [BYTE_W-1:0] wrData,
  input  logic              rdEn,
  output logic [BYTE_W-1:0] rdData,
  output logic              t1FlagSet,
  output logic              t1FlagClr,
  output logic              t2FlagSet,
  output logic              t2FlagClr
);
  localparam int unsigned CNT_W = 2 * BYTE_W;

  timer_strobe_t    strobe;
  logic             contMode;
  logic [CNT_W-1:0] t1Count;
  logic [CNT_W-1:0] t1Latch;
  logic [CNT_W-1:0] t2Count;

  dual_timer_ctrl #(.BYTE_W(BYTE_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .auxCtrl    (auxCtrl),
    .regSel     (regSel),
    .wrEn       (wrEn),
    .rdEn       (rdEn),
    .t1Count    (t1Count),
    .t1Latch    (t1Latch),
    .t2Count    (t2Count),
    .strobe     (strobe),
    .contMode   (contMode),
    .rdData     (rdData),
    .t1ClrPulse (t1FlagClr),
    .t2ClrPulse (t2FlagClr)
  );

  dual_timer_datapath #(.BYTE_W(BYTE_W)) u_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .tickEn   (tickEn),
    .contMode (contMode),
    .strobe   (strobe),
    .wrByte   (wrData),
    .t1Count  (t1Count),
    .t1Latch  (t1Latch),
    .t2Count  (t2Count),
    .t1Event  (t1FlagSet),
    .t2Event  (t2FlagSet)
  );
endmodule

// File: tb/dual_countdown_timer_bench.sv
module dual_countdown_timer_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tickEn = 1'b0;
  logic [7:0] auxCtrl = 8'h40;
  logic [3:0] regSel = 4'd0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic       rdEn = 1'b0;
  logic [7:0] rdData;
  logic       t1FlagSet, t1FlagClr, t2FlagSet, t2FlagClr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // bench model state
  logic [15:0] mT1Cnt = 16'hFFFF;
  logic [15:0] mT1Lat = 16'hFFFF;
  logic        mT1Wrap = 1'b0;
  logic [15:0] mT2Cnt = 16'hFFFF;
  logic [7:0]  mT2Lat = 8'h00;
  logic        mT2Armed = 1'b0;

  always #4 clk = ~clk;

  dual_countdown_timer u_dual_countdown_timer (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .auxCtrl(auxCtrl),
    .regSel(regSel), .wrEn(wrEn), .wrData(wrData), .rdEn(rdEn),
    .rdData(rdData), .t1FlagSet(t1FlagSet), .t1FlagClr(t1FlagClr),
    .t2FlagSet(t2FlagSet), .t2FlagClr(t2FlagClr)
  );

  task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] expRead(input logic [3:0] sel);
    case (sel)
      4'd4: return mT1Cnt[7:0];
      4'd5: return mT1Cnt[15:8];
      4'd6: return mT1Lat[7:0];
      4'd7: return mT1Lat[15:8];
      4'd8: return mT2Cnt[7:0];
      4'd9: return mT2Cnt[15:8];
      default: return 8'h00;
    endcase
  endfunction

  // one bus cycle: drive at negedge, check read, model the edge, check pulses
  task automatic step(input logic w, input logic r, input logic [3:0] sel,
                      input logic [7:0] d, input logic tk, input string rdTag);
    logic eT1Set, eT1Clr, eT2Set, eT2Clr;
    logic [15:0] nT1;
    wrEn = w; rdEn = r; regSel = sel; wrData = d; tickEn = tk;
    #1;
    if (r) chk({8'h00, rdData}, {8'h00, expRead(sel)}, rdTag);
    eT1Set = 1'b0; eT2Set = 1'b0;
    eT1Clr = (w && (sel == 4'd5 || sel == 4'd7)) || (r && sel == 4'd4);
    eT2Clr = r && sel == 4'd8;
    // timer 1
    if (w && sel == 4'd5) begin
      mT1Cnt  = {d, mT1Lat[7:0]};
      mT1Wrap = 1'b0;
    end else if (tk) begin
      if (mT1Wrap) begin nT1 = mT1Lat; mT1Wrap = 1'b0; end
      else if (mT1Cnt == 16'h0) begin nT1 = 16'hFFFF; mT1Wrap = 1'b1; end
      else nT1 = mT1Cnt - 16'd1;
      eT1Set = (auxCtrl[7:6] == 2'b01) && (nT1 == 16'h0);
      mT1Cnt = nT1;
    end
    if (w && (sel == 4'd4 || sel == 4'd6)) mT1Lat[7:0]  = d;
    if (w && (sel == 4'd5 || sel == 4'd7)) mT1Lat[15:8] = d;
    // timer 2
    if (w && sel == 4'd9) begin
      mT2Cnt = {d, mT2Lat}; mT2Armed = 1'b1;
    end else if (tk) begin
      mT2Cnt = mT2Cnt - 16'd1;
      if (mT2Armed && mT2Cnt == 16'h0) begin eT2Set = 1'b1; mT2Armed = 1'b0; end
    end
    if (w && sel == 4'd8) mT2Lat = d;
    @(posedge clk);
    @(negedge clk);
    chk({15'b0, t1FlagSet}, {15'b0, eT1Set}, "R4 t1FlagSet");
    chk({15'b0, t1FlagClr}, {15'b0, eT1Clr}, "R6 R7 R8 t1FlagClr");
    chk({15'b0, t2FlagSet}, {15'b0, eT2Set}, "R11 t2FlagSet");
    chk({15'b0, t2FlagClr}, {15'b0, eT2Clr}, "R10 t2FlagClr");
    wrEn = 1'b0; rdEn = 1'b0; tickEn = 1'b0;
  endtask

  task automatic rd(input logic [3:0] sel, input string tag);
    step(1'b0, 1'b1, sel, 8'h00, 1'b0, tag);
  endtask

  task automatic wr(input logic [3:0] sel, input logic [7:0] d);
    step(1'b1, 1'b0, sel, d, 1'b0, "");
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 4'd0, 8'h00, 1'b1, "");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED1234));
    repeat (3) @(negedge clk);
    // reset state
    chk({15'b0, t1FlagSet | t1FlagClr | t2FlagSet | t2FlagClr}, 16'h0, "R1 pulses in reset");
    rstN = 1'b1;
    rd(4'd4, "R1"); rd(4'd5, "R1"); rd(4'd6, "R1"); rd(4'd7, "R1");
    rd(4'd8, "R1"); rd(4'd9, "R1");

    // R5: low latch writes do not touch the counter
    auxCtrl = 8'h40;
    wr(4'd4, 8'h03);
    rd(4'd4, "R5"); rd(4'd6, "R5");
    wr(4'd6, 8'h03);
    rd(4'd5, "R5");
    // R6: load latch 0x0003, then walk the R3 period
    wr(4'd5, 8'h00);
    rd(4'd4, "R6"); rd(4'd5, "R6");
    chk({8'h00, rdData}, 16'h0000, "R6 high byte after load");
    for (int i = 0; i < 6; i++) begin
      tick(1);
      rd(4'd4, "R3"); rd(4'd5, "R3");
    end
    rd(4'd4, "R3");
    chk({8'h00, rdData}, 16'h0002, "R3 period latch+2 then one more tick");
    rd(4'd5, "R2");
    rd(4'd4, "R2");
    // R4: other modes give no set pulse
    auxCtrl = 8'hC0;
    tick(8);
    auxCtrl = 8'h00;
    tick(8);
    auxCtrl = 8'h40;
    // R7: high latch write without load
    wr(4'd7, 8'h12);
    rd(4'd7, "R7"); rd(4'd5, "R7"); rd(4'd4, "R7");
    // R9/R11 timer 2 one-shot
    wr(4'd8, 8'h02);
    rd(4'd8, "R9"); rd(4'd9, "R9");
    wr(4'd9, 8'h00);
    rd(4'd8, "R9"); rd(4'd9, "R10");
    tick(3);
    rd(4'd8, "R11"); rd(4'd9, "R11");
    chk({8'h00, rdData}, 16'h00FF, "R11 wrap to all ones");
    // R12 load with tick
    step(1'b1, 1'b0, 4'd5, 8'h01, 1'b1, "");
    rd(4'd5, "R12"); rd(4'd4, "R12");
    step(1'b1, 1'b0, 4'd9, 8'h00, 1'b1, "");
    rd(4'd8, "R12");
    // R13 other offsets
    wr(4'd2, 8'hAA); wr(4'd15, 8'h55);
    rd(4'd2, "R13"); rd(4'd15, "R13"); rd(4'd6, "R13"); rd(4'd7, "R13"); rd(4'd8, "R13");

    // constrained random phase
    for (int n = 0; n < 6000; n++) begin
      logic [3:0] sel;
      logic [7:0] d;
      logic w, r, tk;
      int kind;
      sel  = 4'($urandom_range(0, 15));
      kind = $urandom_range(0, 9);
      w    = (kind < 2);
      r    = (kind >= 2 && kind < 4);
      tk   = ($urandom_range(0, 1) == 1);
      d    = 8'($urandom);
      if (w && (sel == 4'd5 || sel == 4'd7 || sel == 4'd9) && $urandom_range(0, 3) != 0) d = 8'h00;
      if (w && (sel == 4'd4 || sel == 4'd6 || sel == 4'd8) && $urandom_range(0, 3) != 0) d = d & 8'h0F;
      auxCtrl = ($urandom_range(0, 3) != 0) ? 8'h40 : 8'($urandom);
      step(w, r, sel, d, tk, (sel == 4'd4 || sel == 4'd5) ? "R2" :
                            (sel == 4'd6 || sel == 4'd7) ? "R8" :
                            (sel == 4'd8 || sel == 4'd9) ? "R10" : "R13");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule